// File: doc/BRIEF.md
# Bidirectional Row-Scan Token Shifter

This block walks one active token across a row of display channels, one position per clock, so that a later high-voltage stage can select one row at a time. A token arriving on the input pin at a rising clock edge empties the whole chain and places a fresh token in the first logical stage. This can happen at any moment, even while an older token is still moving. The register always shifts in its own logical order. A combinational map then turns a logical stage into a physical channel. The map depends on the direction select and on a split-scan select, which starts the scan in the middle of the row.

Each channel leaves the block as a drive-enable bit and a drive-level bit, so the pair can mean drive high, drive low, or float. A polarity input picks the level of the active row, and a global float input releases every channel. Two token pins swap roles with direction: one takes the token in, and the other carries it out to the next device in a chain. The outgoing token is the incoming token delayed by the chain length, and it is updated on the falling clock edge.

Top module: `row_token_shifter`

## Requirements
- R1: A synchronous active-high reset empties all stages and clears the cascade output, so every channel has drive-enable 0 after reset.
- R2: With dir=1, pin A is the token input (pa_en=0) and pin B drives the cascade (pb_en=1). With dir=0 the roles are swapped. The input of whichever pin is driving has no effect.
- R3: When the selected token input is 1 at a rising edge, all stages clear and only logical stage 0 holds a one, even while an older token is still in flight.
- R4: Without a new token, the one advances one logical stage per rising edge and leaves after the last stage. At most one channel is ever enabled.
- R5: With split=0, logical stage s (0..NCH-1) drives channel s+1 (1-based) when dir=1, and channel NCH-s when dir=0.
- R6: With split=1 and NCH=40, the scan order is 21..40 then 1..20 when dir=1, and 20..1 then 40..21 when dir=0.
- R7: The cascade output goes high on the falling edge that follows the rising edge at which the token reached the last stage. That is the token input delayed by NCH rising edges, provided no new token arrived in between.
- R8: An enabled channel has drive-level equal to pol. A floating channel has drive-level 0.
- R9: While float_all=1, every drive-enable is 0, whatever the stages and pol hold. The chain keeps shifting underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages update on the rising edge, cascade on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Direction select; also picks which pin is the token input |
| split | input | 1 | Split-scan select |
| pol | input | 1 | Level for the active channel |
| float_all | input | 1 | 1 releases all channels |
| pa_i | input | 1 | Pin A input value |
| pa_o | output | 1 | Pin A output value (cascade when dir=0) |
| pa_en | output | 1 | Pin A output enable |
| pb_i | input | 1 | Pin B input value |
| pb_o | output | 1 | Pin B output value (cascade when dir=1) |
| pb_en | output | 1 | Pin B output enable |
| ch_en | output | NCH | Per-channel drive enable |
| ch_lvl | output | NCH | Per-channel drive level |

## Verification
A full token walk is run in each of the four direction and split combinations. Each walk shows whether the logical-to-physical map is right, including the wrap at the middle of the row in split mode, and whether the cascade appears exactly one chain length later. A second token injected halfway through a walk, and a token held high for several edges, separate a true clear-and-restart from an OR into stage 0. Noise on the driving pin's input shows whether the pin roles are obeyed. Toggling pol and float_all in the middle of a walk separates the level logic from the enable logic and confirms that shifting carries on while the outputs float.

// File: rtl/row_token_shifter.sv
module row_token_shifter #(
  parameter int NCH = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dir,
  input  logic           split,
  input  logic           pol,
  input  logic           float_all,
  input  logic           pa_i,
  output logic           pa_o,
  output logic           pa_en,
  input  logic           pb_i,
  output logic           pb_o,
  output logic           pb_en,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] ch_lvl
);
  localparam int HALF = NCH / 2;

  logic [NCH-1:0] stage;
  logic [NCH-1:0] act;
  logic           tok_in;
  logic           casc;

  assign tok_in = dir ? pa_i : pb_i;

  always_ff @(posedge clk) begin
    if (rst)         stage <= '0;
    else if (tok_in) stage <= {{(NCH-1){1'b0}}, 1'b1};
    else             stage <= {stage[NCH-2:0], 1'b0};
  end

  always_ff @(negedge clk) begin
    if (rst) casc <= 1'b0;
    else     casc <= stage[NCH-1];
  end

  assign pa_en = ~dir;
  assign pb_en = dir;
  assign pa_o  = ~dir & casc;
  assign pb_o  = dir & casc;

  for (genvar p = 0; p < NCH; p++) begin : g_map
    localparam int KF  = p;
    localparam int KR  = NCH - 1 - p;
    localparam int KSF = (p + NCH - HALF) % NCH;
    localparam int KSR = (NCH - 1 - p + NCH - HALF) % NCH;
    assign act[p] = split ? (dir ? stage[KSF] : stage[KSR])
                          : (dir ? stage[KF]  : stage[KR]);
    assign ch_en[p]  = act[p] & ~float_all;
    assign ch_lvl[p] = act[p] & ~float_all & pol;
  end
endmodule

// File: rtl/row_token_shifter_chk.sv
module row_token_shifter_chk #(
  parameter int NCH = 40
) (
  input logic           clk,
  input logic           rst,
  input logic           dir,
  input logic           pol,
  input logic           float_all,
  input logic           pa_i,
  input logic           pb_i,
  input logic           pa_en,
  input logic           pb_en,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ch_lvl
);
  // R4
  one_active_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ch_en));
  // R9
  float_all_chk: assert property (@(posedge clk) disable iff (rst) float_all |-> ch_en == '0);
  // R2
  pin_role_chk: assert property (@(posedge clk) disable iff (rst) pa_en == ~pb_en && pb_en == dir);
  // R8
  level_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_lvl & ~ch_en) == '0 && (pol ? ch_lvl == ch_en : ch_lvl == '0));
  // R3
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (dir ? pa_i : pb_i) |=> (float_all || $countones(ch_en) == 1));
  // R1
  reset_chk: assert property (@(posedge clk) rst |=> ch_en == '0);
endmodule

bind row_token_shifter row_token_shifter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .dir(dir), .pol(pol), .float_all(float_all),
  .pa_i(pa_i), .pb_i(pb_i), .pa_en(pa_en), .pb_en(pb_en),
  .ch_en(ch_en), .ch_lvl(ch_lvl)
);

// File: tb/row_token_shifter_bench.sv
module row_token_shifter_bench;
  localparam int NCH = 40;
  localparam int PERIOD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1, dir = 1'b1, split = 1'b0, pol = 1'b1, float_all = 1'b0;
  logic pa_i = 1'b0, pb_i = 1'b0;
  logic pa_o, pa_en, pb_o, pb_en;
  logic [NCH-1:0] ch_en, ch_lvl;

  int checks = 0, errors = 0;
  int pos = -1;
  int casc_m = 0;
  bit tok_seen = 0;

  always #(PERIOD/2) clk = ~clk;

  row_token_shifter #(.NCH(NCH)) u_row_token_shifter (
    .clk(clk), .rst(rst), .dir(dir), .split(split), .pol(pol), .float_all(float_all),
    .pa_i(pa_i), .pa_o(pa_o), .pa_en(pa_en), .pb_i(pb_i), .pb_o(pb_o), .pb_en(pb_en),
    .ch_en(ch_en), .ch_lvl(ch_lvl)
  );

  function automatic int chan_of(int s, bit d, bit sp);
    if (!sp) return d ? s + 1 : NCH - s;
    if (d)   return (s < 20) ? 21 + s : s - 19;
    return (s < 20) ? 20 - s : 60 - s;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tok_seen = 0;
    if (rst) pos = -1;
    else if (dir ? pa_i : pb_i) begin pos = 0; tok_seen = 1; end
    else if (pos >= 0) begin pos = pos + 1; if (pos == NCH) pos = -1; end
  end

  always @(negedge clk) casc_m = (!rst && pos == NCH - 1) ? 1 : 0;

  always @(posedge clk) begin
    logic [NCH-1:0] exp_en;
    string tag;
    #(PERIOD/4);
    exp_en = '0;
    if (pos >= 0 && !float_all) exp_en[chan_of(pos, dir, split) - 1] = 1'b1;
    if (rst) tag = "R1";
    else if (float_all) tag = "R9";
    else if (tok_seen) tag = "R3";
    else if (split) tag = "R6";
    else tag = "R5";
    check(ch_en == exp_en, tag, "ch_en", ch_en, exp_en);
    check(ch_lvl == (pol ? exp_en : '0), "R8", "ch_lvl", ch_lvl, pol ? exp_en : '0);
    check($countones(ch_en) <= 1, "R4", "active count", $countones(ch_en), 1);
    check(pb_en == dir && pa_en == !dir, "R2", "pin enables", {pa_en, pb_en}, {!dir, dir});
  end

  always @(negedge clk) begin
    #(PERIOD/4);
    check((dir ? pb_o : pa_o) == casc_m[0], "R7", "cascade", dir ? pb_o : pa_o, casc_m);
    check((dir ? pa_o : pb_o) == 1'b0, "R2", "idle pin value", dir ? pa_o : pb_o, 0);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic token(int len);
    @(negedge clk);
    if (dir) pa_i = 1'b1; else pb_i = 1'b1;
    cyc(len);
    pa_i = 1'b0; pb_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        cyc(3); rst = 1'b0;
        // R5 forward
        dir = 1; split = 0; pol = 1; token(1); cyc(44);
        // R5 reverse, R2 noise on driving pin A
        dir = 0; pol = 0; token(1);
        repeat (10) begin pa_i = 1; cyc(1); pa_i = 0; cyc(2); end
        cyc(16);
        // R6 split both directions
        dir = 1; split = 1; pol = 1; token(1);
        repeat (5) begin pb_i = 1; cyc(1); pb_i = 0; cyc(3); end
        cyc(25);
        dir = 0; token(1); cyc(44);
        // R3 restart mid-flight and held token
        split = 0; dir = 1; token(1); cyc(15); token(1); cyc(10); token(4); cyc(44);
        // R9 float and R8 polarity toggling mid-walk
        token(1); cyc(5); float_all = 1; cyc(8); float_all = 0; cyc(4);
        pol = 0; cyc(6); pol = 1; cyc(25);
        // R1 reset mid-walk
        token(1); cyc(10); rst = 1; cyc(2); rst = 0; cyc(5);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule